// File: doc/BRIEF.md
# Step-Driven Quadrature Divider

This block turns a stream of single-cycle motion steps into a slower quadrature pair. Each step pulse stands for one decoded edge of an incremental encoder, arriving on `step_up` for one sense of rotation and on `step_dn` for the other. A programmable divisor N, from 1 to 4096, sets the ratio. One full output cycle of the A/B pair takes 4×N net steps, and each of its four phases lasts exactly N steps. Both outputs therefore keep a 50% duty cycle when measured in steps, whatever the value of N.

Internally, a bidirectional prescaler counts within 1..N. Its forward and backward wraps rotate a two-bit Gray-coded phase register one position at a time. Because the count is signed and held exactly, motion that backs up retraces the output sequence. No position is lost, and no error builds up. Two sticky flags report the sense of the most recent step. The step inputs are plain control pulses with no handshake and no back-pressure: every pulse that is present at a clock edge is consumed in that cycle. Decoding the raw encoder lines, synchronising them and debouncing them are left to logic upstream.

Top module: `quad_step_divider`

## Requirements
- R1: While reset is held and in the first cycle after it, the outputs are `qa`=1, `qb`=0, `dir_cw`=0 and `dir_ccw`=0.
- R2: The prescaler starts at 1 and counts within 1..N. An up step taken at a count of N or higher reloads 1 and rotates the outputs forward. A down step taken at 1 reloads N and rotates the outputs backward. Every other step only moves the count by one.
- R3: A forward rotation sets `qa` to the old inverted `qb` and `qb` to the old `qa`. The result is the order (qa,qb) = (1,0) → (1,1) → (0,1) → (0,0) → (1,0).
- R4: A backward rotation sets `qa` to the old `qb` and `qb` to the old inverted `qa`. This is the exact reverse of R3.
- R5: Under steady motion with a fixed N, each output phase lasts exactly N steps. With N=1, every step changes the phase.
- R6: A `divisor` value of 0 selects N=4096.
- R7: Any sequence of k up steps followed by k down steps, with N held fixed, leaves `qa`/`qb` where they started.
- R8: A cycle in which `step_up` and `step_dn` are both high is ignored. Count, outputs and flags are all unchanged.
- R9: Each up step sets `dir_cw` and clears `dir_ccw`. Each down step does the reverse. At most one flag is ever high.
- R10: A new N is used from the next step onward. If the count is above the new N, the next up step wraps to 1, and the next down step just decrements.
- R11: Outputs change on the clock edge that takes the step, and at most one of `qa`/`qb` changes per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_up | input | 1 | One-cycle pulse for one forward encoder edge |
| step_dn | input | 1 | One-cycle pulse for one backward encoder edge |
| divisor | input | 12 | Divide ratio N; 0 means 4096 |
| qa | output | 1 | Divided quadrature output A |
| qb | output | 1 | Divided quadrature output B |
| dir_cw | output | 1 | Last step was forward |
| dir_ccw | output | 1 | Last step was backward |

## Verification
The bench builds the block with its default 12-bit divisor width, so the full divisor range is reachable, including the encoding of 4096 as zero. That makes it possible to drive 4096 steps and confirm a single phase boundary at the full ratio. Small ratios (1, 2, 3, 5) keep wrap and reload behaviour dense, so random up/down walks with mid-run divisor changes reach the counter-above-new-N case and N=1 within a few thousand steps.

// File: rtl/quad_step_divider_pkg.sv
package quad_step_divider_pkg;

  typedef enum logic [1:0] {
    MV_NONE = 2'b00,
    MV_FWD  = 2'b01,
    MV_BWD  = 2'b10
  } move_e;

  typedef struct packed {
    logic qa;
    logic qb;
  } quad_t;

  localparam quad_t QUAD_RESET = '{qa: 1'b1, qb: 1'b0};

  function automatic quad_t rotate_fwd(quad_t q);
    quad_t r;
    r.qa = ~q.qb;
    r.qb = q.qa;
    return r;
  endfunction

  function automatic quad_t rotate_bwd(quad_t q);
    quad_t r;
    r.qa = q.qb;
    r.qb = ~q.qa;
    return r;
  endfunction

endpackage

// File: rtl/qsd_step_qualifier.sv
module qsd_step_qualifier
  import quad_step_divider_pkg::*;
(
  input  logic  step_up,
  input  logic  step_dn,
  output move_e move
);

  always_comb begin
    unique case ({step_up, step_dn})
      2'b10:   move = MV_FWD;
      2'b01:   move = MV_BWD;
      default: move = MV_NONE;
    endcase
  end

endmodule

// File: rtl/qsd_prescaler.sv
module qsd_prescaler
  import quad_step_divider_pkg::*;
#(
  parameter int DIV_W = 12,
  localparam int CNT_W = DIV_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  move_e            move,
  input  logic [DIV_W-1:0] divisor,
  output logic             wrap_fwd,
  output logic             wrap_bwd
);

  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
  localparam logic [CNT_W-1:0] FULL_N  = CNT_W'(1) << DIV_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] n_eff;

  // Zero in the divisor field encodes the top ratio 2**DIV_W.
  assign n_eff = (divisor == '0) ? FULL_N : {1'b0, divisor};

  always_comb begin
    cnt_d    = cnt_q;
    wrap_fwd = 1'b0;
    wrap_bwd = 1'b0;
    unique case (move)
      MV_FWD: begin
        if (cnt_q >= n_eff) begin
          cnt_d    = ONE;
          wrap_fwd = 1'b1;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
      MV_BWD: begin
        if (cnt_q <= ONE) begin
          cnt_d    = n_eff;
          wrap_bwd = 1'b1;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= ONE;
    else        cnt_q <= cnt_d;
  end

  // R2: count never leaves 1..2**DIV_W
  a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q >= ONE) && (cnt_q <= FULL_N));

  // R2: forward step at or above N reloads 1
  a_r2_fwd_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (move == MV_FWD && cnt_q >= n_eff) |=> (cnt_q == ONE));

  // R2: backward step at 1 reloads the divisor ratio
  a_r2_bwd_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (move == MV_BWD && cnt_q == ONE) |=> (cnt_q == $past(n_eff)));

  // R8: no move leaves the count alone
  a_r8_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (move == MV_NONE) |=> $stable(cnt_q));

endmodule

// File: rtl/qsd_phase_rotator.sv
module qsd_phase_rotator
  import quad_step_divider_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wrap_fwd,
  input  logic  wrap_bwd,
  output quad_t quad
);

  quad_t quad_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        quad_q <= QUAD_RESET;
    else if (wrap_fwd) quad_q <= rotate_fwd(quad_q);
    else if (wrap_bwd) quad_q <= rotate_bwd(quad_q);
  end

  assign quad = quad_q;

  // R11: Gray order, one output bit at most per cycle
  a_r11_gray_step: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(quad_q ^ $past(quad_q)) <= 1);

  // R3: forward rotation target
  a_r3_fwd_rotate: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_fwd |=> (quad_q.qa == !$past(quad_q.qb)) && (quad_q.qb == $past(quad_q.qa)));

  // R4: backward rotation target
  a_r4_bwd_rotate: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_bwd |=> (quad_q.qa == $past(quad_q.qb)) && (quad_q.qb == !$past(quad_q.qa)));

  // R2: outputs hold without a wrap
  a_r2_hold_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !(wrap_fwd || wrap_bwd) |=> $stable(quad_q));

endmodule

// File: rtl/qsd_dir_flags.sv
module qsd_dir_flags
  import quad_step_divider_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  move_e move,
  output logic  dir_cw,
  output logic  dir_ccw
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_cw  <= 1'b0;
      dir_ccw <= 1'b0;
    end else begin
      unique case (move)
        MV_FWD: begin
          dir_cw  <= 1'b1;
          dir_ccw <= 1'b0;
        end
        MV_BWD: begin
          dir_cw  <= 1'b0;
          dir_ccw <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R9: never both flags
  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dir_cw, dir_ccw}));

  // R8: flags sticky across idle or conflicting cycles
  a_r8_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (move == MV_NONE) |=> $stable({dir_cw, dir_ccw}));

endmodule

// File: rtl/quad_step_divider.sv
module quad_step_divider
  import quad_step_divider_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_up,
  input  logic             step_dn,
  input  logic [DIV_W-1:0] divisor,
  output logic             qa,
  output logic             qb,
  output logic             dir_cw,
  output logic             dir_ccw
);

  move_e move;
  logic  wrap_fwd;
  logic  wrap_bwd;
  quad_t quad;

  qsd_step_qualifier u_qual (
    .step_up (step_up),
    .step_dn (step_dn),
    .move    (move)
  );

  qsd_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .move     (move),
    .divisor  (divisor),
    .wrap_fwd (wrap_fwd),
    .wrap_bwd (wrap_bwd)
  );

  qsd_phase_rotator u_rot (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrap_fwd (wrap_fwd),
    .wrap_bwd (wrap_bwd),
    .quad     (quad)
  );

  qsd_dir_flags u_dir (
    .clk     (clk),
    .rst_n   (rst_n),
    .move    (move),
    .dir_cw  (dir_cw),
    .dir_ccw (dir_ccw)
  );

  assign qa = quad.qa;
  assign qb = quad.qb;

  // R8: both steps at once change nothing visible
  a_r8_conflict_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && step_dn) |=> $stable({qa, qb, dir_cw, dir_ccw}));

  // R2: wraps are mutually exclusive
  a_r2_single_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !(wrap_fwd && wrap_bwd));

endmodule

// File: tb/sim_quad_step_divider.sv
module sim_quad_step_divider;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_up = 1'b0;
  logic        step_dn = 1'b0;
  logic [11:0] divisor = 12'd3;
  logic        qa, qb, dir_cw, dir_ccw;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // bench reference state
  int m_cnt;
  int m_ph;
  bit m_cw, m_ccw;

  always #4 clk = ~clk;

  quad_step_divider u0 (
    .clk(clk), .rst_n(rst_n), .step_up(step_up), .step_dn(step_dn),
    .divisor(divisor), .qa(qa), .qb(qb), .dir_cw(dir_cw), .dir_ccw(dir_ccw)
  );

  function automatic int eff_n(logic [11:0] d);
    return (d == 12'd0) ? 4096 : int'(d);
  endfunction

  function automatic bit ph_a(int p);
    return (p == 0) || (p == 1);
  endfunction

  function automatic bit ph_b(int p);
    return (p == 1) || (p == 2);
  endfunction

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {qa,qb,cw,ccw} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic check_model(string req);
    check(req, {qa, qb, dir_cw, dir_ccw},
          {ph_a(m_ph), ph_b(m_ph), m_cw, m_ccw});
  endtask

  // drive at negedge, let the posedge take it, compare at next negedge
  task automatic do_step(bit up, bit dn, string req);
    int n;
    step_up = up;
    step_dn = dn;
    n = eff_n(divisor);
    @(negedge clk);
    step_up = 1'b0;
    step_dn = 1'b0;
    if (up && !dn) begin
      if (m_cnt >= n) begin m_cnt = 1; m_ph = (m_ph + 1) % 4; end
      else m_cnt++;
      m_cw = 1; m_ccw = 0;
    end else if (dn && !up) begin
      if (m_cnt <= 1) begin m_cnt = n; m_ph = (m_ph + 3) % 4; end
      else m_cnt--;
      m_cw = 0; m_ccw = 1;
    end
    check_model(req);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 in reset", {qa, qb, dir_cw, dir_ccw}, 4'b1000);
    rst_n = 1'b1;
    m_cnt = 1; m_ph = 0; m_cw = 0; m_ccw = 0;
    @(negedge clk);
    check("R1 after reset", {qa, qb, dir_cw, dir_ccw}, 4'b1000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (2) @(negedge clk);
    divisor = 12'd3;
    do_reset();

    // R3/R5: forward sequence with N=3, explicit phase values
    for (int i = 1; i <= 12; i++) begin
      do_step(1, 0, "R5 N=3 forward");
      if (i == 3) check("R3 first fwd phase", {qa, qb, dir_cw, dir_ccw}, 4'b1110);
      if (i == 6) check("R3 second fwd phase", {qa, qb, dir_cw, dir_ccw}, 4'b0110);
      if (i == 9) check("R3 third fwd phase", {qa, qb, dir_cw, dir_ccw}, 4'b0010);
    end
    check("R3 full cycle", {qa, qb, dir_cw, dir_ccw}, 4'b1010);

    // R4: backward from (1,0) at count 1 goes to (0,0)
    do_step(0, 1, "R4 bwd wrap");
    check("R4 bwd to 00", {qa, qb, dir_cw, dir_ccw}, 4'b0001);

    // R7: k up then k down restores outputs
    begin
      logic [1:0] start_q;
      start_q = {qa, qb};
      for (int i = 0; i < 17; i++) do_step(1, 0, "R7 out");
      for (int i = 0; i < 17; i++) do_step(0, 1, "R7 back");
      check("R7 restored", {qa, qb, 2'b01}, {start_q, 2'b01});
    end

    // R8: both asserted ignored
    for (int i = 0; i < 3; i++) do_step(1, 1, "R8 conflict");
    do_step(1, 0, "R9 cw set");
    do_step(1, 1, "R8 flags hold");
    do_step(0, 1, "R9 ccw set");

    // R5: N=1 moves every step
    divisor = 12'd1;
    do_reset();
    for (int i = 0; i < 8; i++) do_step(1, 0, "R5 N=1 fwd");
    for (int i = 0; i < 5; i++) do_step(0, 1, "R5 N=1 bwd");

    // R10: shrink N with count above it
    divisor = 12'd5;
    do_reset();
    for (int i = 0; i < 3; i++) do_step(1, 0, "R10 count to 4");
    divisor = 12'd2;
    do_step(1, 0, "R10 wrap above new N");
    check("R10 wrapped", {qa, qb, dir_cw, dir_ccw}, 4'b1110);
    divisor = 12'd5;
    for (int i = 0; i < 3; i++) do_step(1, 0, "R10 up to 4");
    divisor = 12'd2;
    do_step(0, 1, "R10 down above new N");
    check("R10 no wrap on down", {qa, qb, dir_cw, dir_ccw}, 4'b1101);

    // R6: divisor 0 is 4096
    divisor = 12'd0;
    do_reset();
    for (int i = 0; i < 4095; i++) begin
      step_up = 1'b1;
      @(negedge clk);
      step_up = 1'b0;
      m_cnt++;
    end
    m_cw = 1;
    check_model("R6 no wrap before 4096");
    do_step(1, 0, "R6 wrap at 4096");
    check("R6 phase 1", {qa, qb, dir_cw, dir_ccw}, 4'b1110);
    do_step(0, 1, "R6 back");
    check("R6 reload 4096", {qa, qb, dir_cw, dir_ccw}, 4'b1001);

    // random walk with occasional divisor changes
    divisor = 12'd2;
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 3) begin
        int s;
        s = int'($urandom_range(0, 3));
        divisor = (s == 0) ? 12'd1 : (s == 1) ? 12'd2 : (s == 2) ? 12'd3 : 12'd5;
      end
      r = int'($urandom_range(0, 9));
      if (r < 5)       do_step(1, 0, "R2 random up");
      else if (r < 9)  do_step(0, 1, "R2 random down");
      else             do_step(1, 1, "R8 random conflict");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule